// File: doc/BRIEF.md
# Synthesizer Power and Output-Select Control

This block turns a hardware run pin and a set of software configuration fields into the enables for the three sections of a frequency synthesizer: the IF loop, the RF loop and the shared reference amplifier. The pin has priority: while it is low, every section is off. While it is high, each loop follows its own software enable bit, and a force bit turns both loops on whatever those bits say. The reference amplifier runs whenever either loop runs.

Two RF bands share one RF output, and no software field picks between them. The band that drives the output is the one whose divider register was written last. The block records this from the divider write strobes and gives out one enable per band, so at most one band is ever active. It also gives a one-cycle power-up pulse or power-down pulse each time a section's enable changes, and it drives an auxiliary pin through a small selector. The IF low-bias setting has no effect on the logic here. It is only registered and passed on.

Top module: `synth_pwr_ctrl`

## Requirements
- R1: While `hw_run` is 0, `sec_en` is 3'b000 one cycle later, whatever the software bits are.
- R2: While `hw_run` is 1 and `force_on` is 0, `sec_en[0]` (IF) equals `if_sw_on` and `sec_en[1]` (RF) equals `rf_sw_on`, both one cycle later. A value of 1 means on.
- R3: While `hw_run` is 1 and `force_on` is 1, both `sec_en[0]` and `sec_en[1]` are 1 one cycle later, whatever `if_sw_on` and `rf_sw_on` are.
- R4: `sec_en[2]` (reference amplifier) is 1 exactly when `sec_en[0]` or `sec_en[1]` is 1.
- R5: A pulse on `wr_div_rf1` alone sets `band_sel` to 0, and a pulse on `wr_div_rf2` sets it to 1, one cycle later. When both strobes arrive in the same cycle, `wr_div_rf2` wins. With no strobe, `band_sel` holds its value.
- R6: `rf1_en` is `sec_en[1]` AND NOT `band_sel`, and `rf2_en` is `sec_en[1]` AND `band_sel`. The two are never 1 together.
- R7: When `aux_mode` is 2'b11, `aux_out` shows `unlocked` with one cycle of delay. The codes 2'b00, 2'b01 and 2'b10 drive `aux_out` to 0.
- R8: `sec_up[i]` is 1 for exactly one cycle, in the first cycle that `sec_en[i]` is 1 after being 0. `sec_dn[i]` does the same on a change from 1 to 0. Bit 0 is IF, bit 1 is RF and bit 2 is the reference amplifier.
- R9: After synchronous reset, `sec_en`, `sec_up`, `sec_dn`, `aux_out` and `low_bias_out` are all 0, and `band_sel` is 0 (RF1).
- R10: `low_bias_out` equals `low_bias` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_run | input | 1 | Hardware power pin; 0 turns every section off |
| if_sw_on | input | 1 | Software enable for the IF section |
| rf_sw_on | input | 1 | Software enable for the RF section |
| force_on | input | 1 | Software override that turns both loops on |
| aux_mode | input | 2 | Auxiliary pin selector; 2'b11 routes the lock flag, other codes drive 0 |
| low_bias | input | 1 | IF low-bias setting, passed through |
| wr_div_rf1 | input | 1 | Write strobe of the RF1 divider register |
| wr_div_rf2 | input | 1 | Write strobe of the RF2 divider register |
| unlocked | input | 1 | Lock-detect flag, 1 when not locked |
| sec_en | output | 3 | Section enables {REF, RF, IF} |
| rf1_en | output | 1 | RF1 band active |
| rf2_en | output | 1 | RF2 band active |
| band_sel | output | 1 | Band on the RF output, 0 = RF1, 1 = RF2 |
| sec_up | output | 3 | Power-up request pulses {REF, RF, IF} |
| sec_dn | output | 3 | Power-down request pulses {REF, RF, IF} |
| aux_out | output | 1 | Auxiliary pin level |
| low_bias_out | output | 1 | Registered low-bias setting |

## Verification
Every result comes from one register stage. The enables, the request pulses, the band select, the auxiliary level and the low-bias copy therefore all move at the first clock edge after an input changes. The band enables follow `sec_en` and `band_sel` in that same cycle. The bench drives each input 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. A pulse is checked in the cycle it is due and again one cycle later, when it must be gone again.

// File: rtl/synth_pwr_pkg.sv
package synth_pwr_pkg;

    localparam int NUM_SEC = 3;
    localparam int SEC_IF  = 0;
    localparam int SEC_RF  = 1;
    localparam int SEC_REF = 2;
    localparam int AUX_W   = 2;

    typedef enum logic [AUX_W-1:0] {
        AUX_SPARE0 = 2'b00,
        AUX_LOW    = 2'b01,
        AUX_SPARE2 = 2'b10,
        AUX_UNLOCK = 2'b11
    } aux_mode_e;

    typedef enum logic {
        BAND_RF1 = 1'b0,
        BAND_RF2 = 1'b1
    } band_e;

    typedef struct packed {
        logic ref_on;
        logic rf_on;
        logic if_on;
    } sec_en_t;

    function automatic sec_en_t resolve_power(
        input logic run_pin,
        input logic if_req,
        input logic rf_req,
        input logic force_req
    );
        sec_en_t r;
        r.if_on  = run_pin & (if_req | force_req);
        r.rf_on  = run_pin & (rf_req | force_req);
        r.ref_on = r.if_on | r.rf_on;
        return r;
    endfunction

endpackage

// File: rtl/sec_power_resolve.sv
module sec_power_resolve
    import synth_pwr_pkg::*;
(
    input  logic    hw_run,
    input  logic    if_sw_on,
    input  logic    rf_sw_on,
    input  logic    force_on,
    output sec_en_t en_next
);
    always_comb begin
        en_next = resolve_power(hw_run, if_sw_on, rf_sw_on, force_on);
    end
endmodule

// File: rtl/sec_edge_pulse.sv
module sec_edge_pulse #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_next,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[i] <= 1'b0;
                rise_q[i]  <= 1'b0;
                fall_q[i]  <= 1'b0;
            end else begin
                level_q[i] <= level_next[i];
                rise_q[i]  <= level_next[i] & ~level_q[i];
                fall_q[i]  <= ~level_next[i] & level_q[i];
            end
        end
    end
endmodule

// File: rtl/band_tracker.sv
module band_tracker
    import synth_pwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_lo,
    input  logic  wr_hi,
    output band_e band_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= BAND_RF1;
        end else if (wr_hi) begin
            band_q <= BAND_RF2;
        end else if (wr_lo) begin
            band_q <= BAND_RF1;
        end
    end
endmodule

// File: rtl/aux_select.sv
module aux_select
    import synth_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AUX_W-1:0] mode,
    input  logic             unlocked,
    output logic             aux_q
);
    aux_mode_e mode_e;
    logic      aux_next;

    always_comb begin
        mode_e = aux_mode_e'(mode);
        case (mode_e)
            AUX_UNLOCK: aux_next = unlocked;
            default:    aux_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) aux_q <= 1'b0;
        else     aux_q <= aux_next;
    end
endmodule

// File: rtl/synth_pwr_ctrl.sv
module synth_pwr_ctrl
    import synth_pwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hw_run,
    input  logic               if_sw_on,
    input  logic               rf_sw_on,
    input  logic               force_on,
    input  logic [AUX_W-1:0]   aux_mode,
    input  logic               low_bias,
    input  logic               wr_div_rf1,
    input  logic               wr_div_rf2,
    input  logic               unlocked,
    output logic [NUM_SEC-1:0] sec_en,
    output logic               rf1_en,
    output logic               rf2_en,
    output logic               band_sel,
    output logic [NUM_SEC-1:0] sec_up,
    output logic [NUM_SEC-1:0] sec_dn,
    output logic               aux_out,
    output logic               low_bias_out
);
    sec_en_t en_next;
    band_e   band_q;
    logic    bias_q;

    sec_power_resolve u_resolve (
        .hw_run   (hw_run),
        .if_sw_on (if_sw_on),
        .rf_sw_on (rf_sw_on),
        .force_on (force_on),
        .en_next  (en_next)
    );

    sec_edge_pulse #(.WIDTH(NUM_SEC)) u_edges (
        .clk        (clk),
        .rst        (rst),
        .level_next (en_next),
        .level_q    (sec_en),
        .rise_q     (sec_up),
        .fall_q     (sec_dn)
    );

    band_tracker u_band (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (wr_div_rf1),
        .wr_hi  (wr_div_rf2),
        .band_q (band_q)
    );

    aux_select u_aux (
        .clk      (clk),
        .rst      (rst),
        .mode     (aux_mode),
        .unlocked (unlocked),
        .aux_q    (aux_out)
    );

    always_ff @(posedge clk) begin
        if (rst) bias_q <= 1'b0;
        else     bias_q <= low_bias;
    end

    assign band_sel     = (band_q == BAND_RF2);
    assign rf1_en       = sec_en[SEC_RF] & (band_q == BAND_RF1);
    assign rf2_en       = sec_en[SEC_RF] & (band_q == BAND_RF2);
    assign low_bias_out = bias_q;
endmodule

// File: rtl/synth_pwr_ctrl_chk.sv
module synth_pwr_ctrl_chk
    import synth_pwr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               hw_run,
    input logic               if_sw_on,
    input logic               rf_sw_on,
    input logic               force_on,
    input logic [AUX_W-1:0]   aux_mode,
    input logic               low_bias,
    input logic               wr_div_rf1,
    input logic               wr_div_rf2,
    input logic [NUM_SEC-1:0] sec_en,
    input logic               rf1_en,
    input logic               rf2_en,
    input logic               band_sel,
    input logic [NUM_SEC-1:0] sec_up,
    input logic [NUM_SEC-1:0] sec_dn,
    input logic               aux_out,
    input logic               low_bias_out
);
    a_r1_pin_off: assert property (@(posedge clk) disable iff (rst)
        !hw_run |=> (sec_en == '0));

    a_r2_if_follow: assert property (@(posedge clk) disable iff (rst)
        (hw_run && !force_on) |=> (sec_en[SEC_IF] == $past(if_sw_on) &&
                                   sec_en[SEC_RF] == $past(rf_sw_on)));

    a_r3_force_on: assert property (@(posedge clk) disable iff (rst)
        (hw_run && force_on) |=> (sec_en[SEC_IF] && sec_en[SEC_RF]));

    a_r4_ref_follows: assert property (@(posedge clk) disable iff (rst)
        sec_en[SEC_REF] == (sec_en[SEC_IF] || sec_en[SEC_RF]));

    a_r5_band_rf2: assert property (@(posedge clk) disable iff (rst)
        wr_div_rf2 |=> band_sel);

    a_r5_band_rf1: assert property (@(posedge clk) disable iff (rst)
        (wr_div_rf1 && !wr_div_rf2) |=> !band_sel);

    a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_div_rf1 && !wr_div_rf2) |=> $stable(band_sel));

    a_r6_one_band: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf1_en, rf2_en}));

    a_r7_aux_low: assert property (@(posedge clk) disable iff (rst)
        (aux_mode != 2'b11) |=> !aux_out);

    a_r8_up_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_en[SEC_IF]) |-> sec_up[SEC_IF]);

    a_r8_dn_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(sec_en[SEC_RF]) |-> sec_dn[SEC_RF]);

    a_r8_no_both: assert property (@(posedge clk) disable iff (rst)
        (sec_up & sec_dn) == '0);

    a_r10_bias: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (low_bias_out == $past(low_bias)));
endmodule

bind synth_pwr_ctrl synth_pwr_ctrl_chk u_chk (.*);

// File: tb/tb_synth_pwr_ctrl.sv
module tb_synth_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       hw_run, if_sw_on, rf_sw_on, force_on;
    logic [1:0] aux_mode;
    logic       low_bias, wr_div_rf1, wr_div_rf2, unlocked;
    logic [2:0] sec_en, sec_up, sec_dn;
    logic       rf1_en, rf2_en, band_sel, aux_out, low_bias_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    synth_pwr_ctrl dut (
        .clk(clk), .rst(rst), .hw_run(hw_run), .if_sw_on(if_sw_on),
        .rf_sw_on(rf_sw_on), .force_on(force_on), .aux_mode(aux_mode),
        .low_bias(low_bias), .wr_div_rf1(wr_div_rf1), .wr_div_rf2(wr_div_rf2),
        .unlocked(unlocked), .sec_en(sec_en), .rf1_en(rf1_en), .rf2_en(rf2_en),
        .band_sel(band_sel), .sec_up(sec_up), .sec_dn(sec_dn),
        .aux_out(aux_out), .low_bias_out(low_bias_out)
    );

    // {hw_run, if_sw_on, rf_sw_on, force_on, exp IF, exp RF, exp REF}
    localparam logic [6:0] VEC [0:9] = '{
        7'b0111_000,   // R1
        7'b0001_000,   // R1
        7'b1000_000,   // R2
        7'b1100_101,   // R2
        7'b1010_011,   // R2
        7'b1110_111,   // R2
        7'b1001_111,   // R3
        7'b1011_111,   // R3
        7'b0101_000,   // R1
        7'b1100_101    // R2
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hw_run = 1'b1; if_sw_on = 1'b1; rf_sw_on = 1'b1; force_on = 1'b0;
        aux_mode = 2'b11; low_bias = 1'b1; wr_div_rf1 = 1'b0; wr_div_rf2 = 1'b1;
        unlocked = 1'b1;
        step(); step();
        // R9 reset state
        check("R9 sec_en", {5'b0, sec_en}, 8'h0);
        check("R9 pulses", {2'b0, sec_up, sec_dn}, 8'h0);
        check("R9 band/aux/bias", {5'b0, band_sel, aux_out, low_bias_out}, 8'h0);
        hw_run = 1'b0; if_sw_on = 1'b0; rf_sw_on = 1'b0; wr_div_rf2 = 1'b0;
        aux_mode = 2'b01; low_bias = 1'b0; unlocked = 1'b0;
        rst = 1'b0;
        step();

        for (int i = 0; i < 10; i++) begin
            hw_run   = VEC[i][6];
            if_sw_on = VEC[i][5];
            rf_sw_on = VEC[i][4];
            force_on = VEC[i][3];
            step();
            check($sformatf("R1/R2/R3/R4 vector %0d", i), {5'b0, sec_en},
                  {5'b0, VEC[i][0], VEC[i][1], VEC[i][2]});
        end

        // R8 pulses: current state IF on; turn RF on
        rf_sw_on = 1'b1;
        step();
        check("R8 rf up pulse", {2'b0, sec_up, sec_dn}, {2'b0, 3'b010, 3'b000});
        step();
        check("R8 up pulse ends", {2'b0, sec_up, sec_dn}, 8'h0);
        hw_run = 1'b0;
        step();
        check("R8 all down pulse", {2'b0, sec_up, sec_dn}, {2'b0, 3'b000, 3'b111});
        step();
        check("R8 dn pulse ends", {2'b0, sec_up, sec_dn}, 8'h0);
        hw_run = 1'b1; if_sw_on = 1'b0;
        step();
        check("R8 rf+ref up", {2'b0, sec_up, sec_dn}, {2'b0, 3'b110, 3'b000});

        // R5 / R6 band tracking, RF on
        check("R6 rf1 after reset", {6'b0, rf1_en, rf2_en}, 8'h2);
        wr_div_rf2 = 1'b1;
        step();
        wr_div_rf2 = 1'b0;
        check("R5 rf2 write", {7'b0, band_sel}, 8'h1);
        check("R6 rf2 active", {6'b0, rf1_en, rf2_en}, 8'h1);
        step();
        check("R5 hold", {7'b0, band_sel}, 8'h1);
        wr_div_rf1 = 1'b1;
        step();
        wr_div_rf1 = 1'b0;
        check("R5 rf1 write", {7'b0, band_sel}, 8'h0);
        wr_div_rf1 = 1'b1; wr_div_rf2 = 1'b1;
        step();
        wr_div_rf1 = 1'b0; wr_div_rf2 = 1'b0;
        check("R5 both strobes rf2 wins", {7'b0, band_sel}, 8'h1);
        rf_sw_on = 1'b0;
        step();
        check("R6 rf off no band", {6'b0, rf1_en, rf2_en}, 8'h0);

        // R7 aux selector
        aux_mode = 2'b11; unlocked = 1'b1;
        step();
        check("R7 unlock routed", {7'b0, aux_out}, 8'h1);
        unlocked = 1'b0;
        step();
        check("R7 lock routed", {7'b0, aux_out}, 8'h0);
        unlocked = 1'b1;
        for (int m = 0; m < 3; m++) begin
            aux_mode = 2'(m);
            step();
            check($sformatf("R7 mode %0d low", m), {7'b0, aux_out}, 8'h0);
        end

        // R10 bias pass-through
        low_bias = 1'b1;
        step();
        check("R10 bias high", {7'b0, low_bias_out}, 8'h1);
        low_bias = 1'b0;
        step();
        check("R10 bias low", {7'b0, low_bias_out}, 8'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule